// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block watches three 8-bit groups of input pins, called port A, port B and port F, and turns their activity into interrupt requests. Every line can be set to respond either to a level (high or low) or to an edge (rising or falling). Edge events are held in a flag until software acknowledges them. A level condition is reported for as long as it lasts. Each line can be enabled on its own, and each line can pass its input through a debounce filter before detection.

Software reaches the block over a byte-wide register bus with an address, a write strobe, a read strobe and read and write data. Every port has its own bank of registers: mode, polarity, acknowledge, enable, status and debounce. Ports A and B together drive one combined request line. Each line of port F has a request output of its own, so a processor can route those eight lines directly.

Top module: `gpint_ctrl`

## Requirements
- R1: The mode, polarity, enable and debounce registers of each port can be written and read back. Port bank bases are A 0x90, B 0xAC and F 0x4C. Within a bank: mode +0x00, polarity +0x04, acknowledge +0x08, enable +0x0C, status +0x10, debounce +0x18. Read data appears in the cycle after the read strobe, and it is 0x00 in any cycle that follows no read.
- R2: A line whose mode bit is 0 is level-sensitive. It is active while its filtered input equals its polarity bit (1 = high, 0 = low).
- R3: A line whose mode bit is 1 is edge-sensitive. A transition of its filtered input in the chosen direction (polarity 1 = rising, 0 = falling) sets a latched flag, and the flag stays set after the input returns.
- R4: A line with its enable bit at 0 never shows in status or on any request output. Clearing the enable bit discards a latched edge flag, so that flag does not come back when the bit is set again.
- R5: Writing a mask to a port's acknowledge register clears the latched flags of the lines whose mask bits are 1 and leaves the others alone. The acknowledge register reads as 0x00.
- R6: The status register of a port returns, per enabled line, the latched flag in edge mode or the live level condition in level mode. Writes to it have no effect.
- R7: The combined request output is 1 exactly when any status bit of port A or port B is 1.
- R8: Request output bit i of port F equals status bit i of port F.
- R9: Pins pass through two synchronizing flops and one filter stage. A pin change seen at clock edge k reaches a level-mode status after edge k+2 and an edge-mode flag after edge k+3.
- R10: With its debounce bit set, a line takes a new input value only after the synchronized input has differed from the accepted value for DB_CYCLES consecutive cycles (default 16). Shorter pulses are ignored.
- R11: After reset, every register reads 0x00 and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| pins_a | input | 8 | Port A pin inputs (asynchronous) |
| pins_b | input | 8 | Port B pin inputs (asynchronous) |
| pins_f | input | 8 | Port F pin inputs (asynchronous) |
| irq_ab | output | 1 | Combined request of ports A and B |
| irq_f | output | 8 | Per-line requests of port F |

## Verification
The assertions assume that the bus strobes are clean single-cycle pulses driven between clock edges, and that a write to the port F enable register carries the intended mask in the same cycle as the strobe. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. As a result, decoding, read timing and enable gating are only ever checked against well-formed accesses. Pin changes in the random phase are held for several cycles, so both the non-debounced and the debounced lines see transitions that the reference model can follow cycle for cycle.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    localparam int NUM_PORTS = 3;
    localparam int LINE_W    = 8;
    localparam int ADDR_W    = 8;

    // register offsets inside one port bank
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DB   = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_POL,
        SEL_ACK,
        SEL_EN,
        SEL_STAT,
        SEL_DB
    } sel_kind_e;

    typedef struct packed {
        logic      hit;
        logic [1:0] port;
        sel_kind_e kind;
    } reg_sel_t;

    typedef struct packed {
        logic [LINE_W-1:0] mode;
        logic [LINE_W-1:0] pol;
        logic [LINE_W-1:0] en;
        logic [LINE_W-1:0] db;
    } port_cfg_t;

    // bank base: index 0 = port A, 1 = port B, 2 = port F
    function automatic logic [ADDR_W-1:0] bank_base(input int unsigned p);
        logic [ADDR_W-1:0] b;
        case (p)
            0:       b = 8'h90;
            1:       b = 8'hAC;
            default: b = 8'h4C;
        endcase
        return b;
    endfunction

    function automatic sel_kind_e kind_of(input logic [ADDR_W-1:0] d);
        sel_kind_e k;
        case (d)
            OFS_MODE: k = SEL_MODE;
            OFS_POL:  k = SEL_POL;
            OFS_ACK:  k = SEL_ACK;
            OFS_EN:   k = SEL_EN;
            OFS_STAT: k = SEL_STAT;
            OFS_DB:   k = SEL_DB;
            default:  k = SEL_NONE;
        endcase
        return k;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t  s;
        sel_kind_e k;
        s.hit  = 1'b0;
        s.port = 2'd0;
        s.kind = SEL_NONE;
        for (int p = 0; p < NUM_PORTS; p++) begin
            k = kind_of(a - bank_base(p));
            if (k != SEL_NONE) begin
                s.hit  = 1'b1;
                s.port = 2'(p);
                s.kind = k;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpint_infilt.sv
module gpint_infilt #(
    parameter int DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic db_en,
    output logic level
);
    localparam int CNT_W = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            level  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (!db_en) begin
                level <= sync_q[1];
                cnt_q <= '0;
            end else if (sync_q[1] == level) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                level <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect
    import gpint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] filt,
    input  port_cfg_t         cfg,
    input  logic [LINE_W-1:0] ack_mask,
    output logic [LINE_W-1:0] status
);
    logic [LINE_W-1:0] prev_q;
    logic [LINE_W-1:0] latch_q;
    logic [LINE_W-1:0] rise, fall, evt, lvl_hit;

    always_comb begin
        rise    = filt & ~prev_q;
        fall    = ~filt & prev_q;
        evt     = cfg.mode & cfg.en & ((cfg.pol & rise) | (~cfg.pol & fall));
        lvl_hit = ~(filt ^ cfg.pol);
        status  = cfg.en & ((cfg.mode & latch_q) | (~cfg.mode & lvl_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= filt;
            latch_q <= ((latch_q & ~ack_mask) | evt) & cfg.en & cfg.mode;
        end
    end
endmodule

// File: rtl/gpint_bank.sv
module gpint_bank
    import gpint_pkg::*;
#(
    parameter int DB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] pins,
    input  logic              wr_en,
    input  sel_kind_e         kind,
    input  logic [LINE_W-1:0] wdata,
    output port_cfg_t         cfg,
    output logic [LINE_W-1:0] status
);
    logic [LINE_W-1:0] filt;
    logic [LINE_W-1:0] ack_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (kind)
                SEL_MODE: cfg.mode <= wdata;
                SEL_POL:  cfg.pol  <= wdata;
                SEL_EN:   cfg.en   <= wdata;
                SEL_DB:   cfg.db   <= wdata;
                default:  ;
            endcase
        end
    end

    assign ack_mask = (wr_en && kind == SEL_ACK) ? wdata : '0;

    for (genvar i = 0; i < LINE_W; i++) begin : g_line
        gpint_infilt #(.DB_CYCLES(DB_CYCLES)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .pin   (pins[i]),
            .db_en (cfg.db[i]),
            .level (filt[i])
        );
    end

    gpint_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .filt     (filt),
        .cfg      (cfg),
        .ack_mask (ack_mask),
        .status   (status)
    );
endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
    import gpint_pkg::*;
#(
    parameter int DB_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pins_a,
    input  logic [7:0]  pins_b,
    input  logic [7:0]  pins_f,
    output logic        irq_ab,
    output logic [7:0]  irq_f
);
    reg_sel_t          sel;
    port_cfg_t         cfg_arr  [NUM_PORTS];
    logic [LINE_W-1:0] stat_arr [NUM_PORTS];
    logic [LINE_W-1:0] pin_arr  [NUM_PORTS];
    logic [LINE_W-1:0] rd_mux;

    assign sel        = decode_addr(bus_addr);
    assign pin_arr[0] = pins_a;
    assign pin_arr[1] = pins_b;
    assign pin_arr[2] = pins_f;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpint_bank #(.DB_CYCLES(DB_CYCLES)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .pins   (pin_arr[p]),
            .wr_en  (bus_wr && sel.hit && sel.port == 2'(p)),
            .kind   (sel.kind),
            .wdata  (bus_wdata),
            .cfg    (cfg_arr[p]),
            .status (stat_arr[p])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel.hit && sel.port == 2'(p)) begin
                case (sel.kind)
                    SEL_MODE: rd_mux = cfg_arr[p].mode;
                    SEL_POL:  rd_mux = cfg_arr[p].pol;
                    SEL_EN:   rd_mux = cfg_arr[p].en;
                    SEL_DB:   rd_mux = cfg_arr[p].db;
                    SEL_STAT: rd_mux = stat_arr[p];
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= bus_rd ? rd_mux : '0;
    end

    assign irq_ab = (|stat_arr[0]) | (|stat_arr[1]);
    assign irq_f  = stat_arr[2];
endmodule

// File: rtl/gpint_chk.sv
module gpint_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq_ab,
    input logic [7:0] irq_f,
    input logic [7:0] en_f,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b
);
    localparam logic [7:0] F_EN_ADDR = 8'h58;

    // R4: a disabled port F line never raises its request
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_f & ~en_f) == 8'h00);

    // R1: an enable write on port F is visible in the next cycle
    a_r1_enable_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == F_EN_ADDR) |=> (en_f == $past(bus_wdata)));

    // R1: read data is zero after a cycle without a read strobe
    a_r1_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 8'h00));

    // R7: pending status on port A or B drives the combined request
    a_r7_shared_a: assert property (@(posedge clk) disable iff (rst)
        (stat_a != 8'h00) |-> irq_ab);

    a_r7_shared_b: assert property (@(posedge clk) disable iff (rst)
        (stat_b != 8'h00) |-> irq_ab);

    // R7: no request without a pending status on either port
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        irq_ab |-> ((stat_a | stat_b) != 8'h00));
endmodule

bind gpint_ctrl gpint_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_ab    (irq_ab),
    .irq_f     (irq_f),
    .en_f      (cfg_arr[2].en),
    .stat_a    (stat_arr[0]),
    .stat_b    (stat_arr[1])
);

// File: tb/sim_gpint_ctrl.sv
module sim_gpint_ctrl;
    localparam int DBC = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] pins_a = 8'h00;
    logic [7:0] pins_b = 8'h00;
    logic [7:0] pins_f = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ab;
    logic [7:0] irq_f;

    always #5 clk = ~clk;

    gpint_ctrl #(.DB_CYCLES(DBC)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_a(pins_a), .pins_b(pins_b), .pins_f(pins_f),
        .irq_ab(irq_ab), .irq_f(irq_f)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string tag = "R11";

    // ---------------- reference model ----------------
    logic [7:0] m_mode[3], m_pol[3], m_en[3], m_db[3];
    logic [7:0] m_s1[3], m_s2[3], m_flt[3], m_prev[3], m_lat[3];
    int         m_cnt[3][8];
    logic [7:0] m_rd;
    logic [7:0] m_evt, m_ack, m_pin, m_d;

    function automatic logic [7:0] base_of(input int p);
        return (p == 0) ? 8'h90 : (p == 1) ? 8'hAC : 8'h4C;
    endfunction

    function automatic logic [7:0] m_stat(input int p);
        return m_en[p] & ((m_mode[p] & m_lat[p]) | (~m_mode[p] & ~(m_flt[p] ^ m_pol[p])));
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [7:0] d;
        for (int p = 0; p < 3; p++) begin
            d = a - base_of(p);
            if (d == 8'h00) return m_mode[p];
            if (d == 8'h04) return m_pol[p];
            if (d == 8'h0C) return m_en[p];
            if (d == 8'h10) return m_stat(p);
            if (d == 8'h18) return m_db[p];
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 3; p++) begin
                m_mode[p] = 0; m_pol[p] = 0; m_en[p] = 0; m_db[p] = 0;
                m_s1[p] = 0; m_s2[p] = 0; m_flt[p] = 0; m_prev[p] = 0; m_lat[p] = 0;
                for (int i = 0; i < 8; i++) m_cnt[p][i] = 0;
            end
            m_rd = 8'h00;
        end else begin
            m_rd = bus_rd ? m_read(bus_addr) : 8'h00;
            for (int p = 0; p < 3; p++) begin
                m_pin = (p == 0) ? pins_a : (p == 1) ? pins_b : pins_f;
                m_evt = m_mode[p] & m_en[p] &
                        ((m_pol[p] & m_flt[p] & ~m_prev[p]) | (~m_pol[p] & ~m_flt[p] & m_prev[p]));
                m_ack = (bus_wr && bus_addr == base_of(p) + 8'h08) ? bus_wdata : 8'h00;
                m_lat[p]  = ((m_lat[p] & ~m_ack) | m_evt) & m_en[p] & m_mode[p];
                m_prev[p] = m_flt[p];
                for (int i = 0; i < 8; i++) begin
                    if (!m_db[p][i]) begin
                        m_flt[p][i] = m_s2[p][i];
                        m_cnt[p][i] = 0;
                    end else if (m_s2[p][i] == m_flt[p][i]) begin
                        m_cnt[p][i] = 0;
                    end else if (m_cnt[p][i] == DBC - 1) begin
                        m_flt[p][i] = m_s2[p][i];
                        m_cnt[p][i] = 0;
                    end else begin
                        m_cnt[p][i] = m_cnt[p][i] + 1;
                    end
                end
                m_s2[p] = m_s1[p];
                m_s1[p] = m_pin;
                if (bus_wr) begin
                    m_d = bus_addr - base_of(p);
                    if (m_d == 8'h00) m_mode[p] = bus_wdata;
                    if (m_d == 8'h04) m_pol[p]  = bus_wdata;
                    if (m_d == 8'h0C) m_en[p]   = bus_wdata;
                    if (m_d == 8'h18) m_db[p]   = bus_wdata;
                end
            end
        end
    end

    task automatic check(input string t, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check({tag, " R7/R8 outputs"}, {irq_ab, irq_f},
                  {(|m_stat(0)) | (|m_stat(1)), m_stat(2)});
            check({tag, " R1 rdata"}, {1'b0, bus_rdata}, {1'b0, m_rd});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        tag = "R11";
        for (int p = 0; p < 3; p++) begin
            rd(base_of(p), v);          check("R11 mode", {1'b0, v}, 9'h0);
            rd(base_of(p) + 8'h0C, v);  check("R11 enable", {1'b0, v}, 9'h0);
            rd(base_of(p) + 8'h10, v);  check("R11 status", {1'b0, v}, 9'h0);
        end
        check("R11 irq", {irq_ab, irq_f}, 9'h0);

        // R1: write and read back, R5: acknowledge reads zero
        tag = "R1";
        wr(8'h4C, 8'hA5); rd(8'h4C, v); check("R1 mode F", {1'b0, v}, 9'h0A5);
        wr(8'h50, 8'h3C); rd(8'h50, v); check("R1 pol F", {1'b0, v}, 9'h03C);
        wr(8'h64, 8'h81); rd(8'h64, v); check("R1 db F", {1'b0, v}, 9'h081);
        rd(8'h54, v); check("R5 ack reads zero", {1'b0, v}, 9'h000);
        wr(8'hA0, 8'hFF); rd(8'hA0, v); check("R6 status write ignored", {1'b0, v}, 9'h000);
        wr(8'h4C, 8'h00); wr(8'h50, 8'h00); wr(8'h64, 8'h00);

        // R2: level mode on port A
        tag = "R2";
        wr(8'h90, 8'h00); wr(8'h94, 8'h0F); wr(8'h9C, 8'hFF);
        rd(8'hA0, v); check("R2 low lines active", {1'b0, v}, 9'h0F0);
        check("R7 shared from A", {8'h0, irq_ab}, 9'h1);
        pins_a = 8'h0F;
        repeat (4) @(negedge clk);
        rd(8'hA0, v); check("R2 all active", {1'b0, v}, 9'h0FF);
        pins_a = 8'hF0;
        repeat (4) @(negedge clk);
        rd(8'hA0, v); check("R2 none active", {1'b0, v}, 9'h000);
        check("R7 shared idle", {8'h0, irq_ab}, 9'h0);

        // R9: latency of a level change
        tag = "R9";
        pins_a = 8'hF1;
        @(negedge clk); @(negedge clk);
        check("R9 level not yet", {8'h0, irq_ab}, 9'h0);
        @(negedge clk);
        check("R9 level after k+2", {8'h0, irq_ab}, 9'h1);
        wr(8'h9C, 8'h00);
        check("R4 port A disabled", {8'h0, irq_ab}, 9'h0);

        // R3: edge mode on port F, lines 0-3 rising, 4-7 falling
        tag = "R3";
        wr(8'h4C, 8'hFF); wr(8'h50, 8'h0F); wr(8'h58, 8'hFF);
        pins_f = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 edge not yet", {1'b0, irq_f}, 9'h000);
        @(negedge clk);
        check("R3 rising latched", {1'b0, irq_f}, 9'h00F);
        repeat (5) @(negedge clk);
        check("R3 flag held", {1'b0, irq_f}, 9'h00F);

        // R5: partial acknowledge
        tag = "R5";
        wr(8'h54, 8'h03);
        check("R5 partial ack", {1'b0, irq_f}, 9'h00C);
        pins_f = 8'h00;
        repeat (5) @(negedge clk);
        check("R3 falling latched", {1'b0, irq_f}, 9'h0FC);
        check("R8 per-line outputs", {1'b0, irq_f}, 9'h0FC);

        // R4: disabling discards the flag
        tag = "R4";
        wr(8'h58, 8'hFB);
        check("R4 disabled line masked", {1'b0, irq_f}, 9'h0F8);
        @(negedge clk);
        wr(8'h58, 8'hFF);
        @(negedge clk);
        check("R4 flag discarded", {1'b0, irq_f}, 9'h0F8);
        wr(8'h54, 8'hFF);
        check("R5 full ack", {1'b0, irq_f}, 9'h000);

        // R6/R7: port B edge on line 7 through the shared output
        tag = "R7";
        wr(8'hAC, 8'h80); wr(8'hB0, 8'h80); wr(8'hB8, 8'h80);
        pins_b = 8'h80;
        repeat (5) @(negedge clk);
        check("R7 shared from B", {8'h0, irq_ab}, 9'h1);
        rd(8'hBC, v); check("R6 status B", {1'b0, v}, 9'h080);
        wr(8'hB4, 8'h80);
        check("R7 shared cleared", {8'h0, irq_ab}, 9'h0);

        // R10: debounce on port F line 0
        tag = "R10";
        wr(8'h64, 8'h01);
        pins_f = 8'h01;
        repeat (10) @(negedge clk);
        pins_f = 8'h00;
        repeat (30) @(negedge clk);
        check("R10 short pulse ignored", {1'b0, irq_f}, 9'h000);
        pins_f = 8'h01;
        repeat (18) @(negedge clk);
        check("R10 not yet accepted", {1'b0, irq_f}, 9'h000);
        @(negedge clk);
        check("R10 accepted after hold", {1'b0, irq_f}, 9'h001);
        wr(8'h54, 8'hFF);

        // random traffic against the model
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 5) == 0) pins_a = 8'($urandom);
            if ($urandom_range(0, 5) == 0) pins_b = 8'($urandom);
            if ($urandom_range(0, 3) == 0) pins_f = pins_f ^ 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) begin
                bus_wr    = 1'b1;
                bus_addr  = base_of($urandom_range(0, 2)) + 8'(4 * $urandom_range(0, 6));
                bus_wdata = 8'($urandom);
            end else if ($urandom_range(0, 3) == 0) begin
                bus_rd   = 1'b1;
                bus_addr = base_of($urandom_range(0, 2)) + 8'(4 * $urandom_range(0, 6));
            end
            @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule